// File: doc/BRIEF.md
# Pulse-Width Angle Frame Encoder

This block turns a shaft angle into a fixed-length pulse-width frame on one output pin. Time is measured in PWM periods, each one marked by a single-cycle strobe on `pwm_tick_i`. Every frame has three parts. A preamble comes first, and its last four periods report the fault state. A data section follows, and its high time grows by one period per angle step. A low tail closes the frame. The angle on this output is the raw measurement, with no latency correction applied. A receiver recovers the angle by measuring the high time and subtracting the preamble.

The 14-bit angle input is reduced to 12 bits by dropping its two least significant bits. One step is then roughly 0.088 degrees, and a period typically lasts about 444 ns. The angle and the fault flag are captured once, on the strobe that begins a frame. They are held until the next frame begins, so a receiver always sees one consistent value per frame. When `enable_i` is low, the pin is forced low and the frame position returns to its start.

Top module: `pwm_angle_frame_enc`

## Requirements
- R1: After reset the output is low, and it stays low until the first strobe with enable high. That strobe begins period 0 of a frame.
- R2: A frame is 4119 periods long and frames follow one another with no gap. The output changes only on a clock edge where the strobe is high, or where enable is low.
- R3: Periods 0 to 11 of every frame are high, whatever the fault state.
- R4: Periods 12 to 15 are high when the captured fault flag is 0, and low when it is 1.
- R5: With no fault, the 4095 data periods (16 to 4110) are high for the first N periods and low for the rest. N is the captured 12-bit angle. N = 0 gives no high data period, and N = 4095 makes the whole data section high.
- R6: With the captured fault flag at 1, the whole data section is low, so the frame is high for exactly 12 periods.
- R7: The last 8 periods of every frame (4111 to 4118) are low.
- R8: The angle and the fault flag are sampled only on the strobe that starts period 0. Changes at any other time have no effect on the frame in progress.
- R9: With enable low, the output goes low on the next clock edge and stays low, and the frame position returns to 0. After enable returns high, the next strobe starts a new frame at period 0.
- R10: N equals angle bits 13:2. Bits 1:0 have no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Output enable. Low forces the pin low and restarts the frame |
| pwm_tick_i | input | 1 | One-cycle strobe that advances the frame by one PWM period |
| angle_i | input | 14 | Measured angle, full-scale 14-bit |
| fault_i | input | 1 | Diagnostic fault flag, captured at the start of each frame |
| pwm_o | output | 1 | Encoded pulse-width output |

## Verification
Two events can land on the same clock edge. One is the wrap from the last tail period into period 0. The other is the capture of a new angle and fault value, and the angle input may also be changing on that edge. The bench sets a new angle on the cycle just before the wrap strobe and changes the angle and fault again in the middle of each frame. Each frame is judged by comparing every period with a model built from the requirements, and by checking that the total high count matches the value captured at the start. A second overlap, a disable arriving together with a strobe, is provoked mid-frame and judged by the pin going low on the next edge.

// File: rtl/pwm_frame_pkg.sv
package pwm_frame_pkg;

    // Section of the frame that the current period belongs to
    typedef enum logic [1:0] {
        SEG_INIT = 2'd0,
        SEG_FLAG = 2'd1,
        SEG_DATA = 2'd2,
        SEG_TAIL = 2'd3
    } frame_seg_e;

endpackage

// File: rtl/pwm_frame_timer.sv
module pwm_frame_timer
    import pwm_frame_pkg::*;
#(
    parameter int unsigned INIT_LEN = 12,
    parameter int unsigned FLAG_LEN = 4,
    parameter int unsigned DATA_W   = 12,
    parameter int unsigned TAIL_LEN = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              tick_i,
    output frame_seg_e        seg_o,
    output logic [DATA_W-1:0] data_idx_o,
    output logic              start_o
);

    localparam int unsigned DATA_LEN  = (1 << DATA_W) - 1;
    localparam int unsigned FLAG_BASE = INIT_LEN;
    localparam int unsigned DATA_BASE = INIT_LEN + FLAG_LEN;
    localparam int unsigned TAIL_BASE = DATA_BASE + DATA_LEN;
    localparam int unsigned FRAME_LEN = TAIL_BASE + TAIL_LEN;
    localparam int unsigned CNT_W     = $clog2(FRAME_LEN);
    localparam int unsigned LAST      = FRAME_LEN - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } timer_state_t;

    timer_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (st_q.cnt == CNT_W'(LAST)) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        if (st_q.cnt < CNT_W'(FLAG_BASE)) begin
            seg_o = SEG_INIT;
        end else if (st_q.cnt < CNT_W'(DATA_BASE)) begin
            seg_o = SEG_FLAG;
        end else if (st_q.cnt < CNT_W'(TAIL_BASE)) begin
            seg_o = SEG_DATA;
        end else begin
            seg_o = SEG_TAIL;
        end
    end

    assign data_idx_o = DATA_W'(st_q.cnt - CNT_W'(DATA_BASE));
    assign start_o    = en_i && tick_i && (st_q.cnt == '0);

    // R2: a strobe in the last period wraps to the first
    assert_frame_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && tick_i && seg_o == SEG_TAIL && st_q.cnt == CNT_W'(LAST)) |=> (st_q.cnt == '0));

    // R2: position does not move without a strobe
    assert_idle_position_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !tick_i) |=> $stable(st_q.cnt));

    // R9: disabling returns the frame to its start
    assert_disable_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (seg_o == SEG_INIT && data_idx_o == DATA_W'(0 - DATA_BASE)));

endmodule

// File: rtl/pwm_frame_sampler.sv
module pwm_frame_sampler #(
    parameter int unsigned ANGLE_W = 14,
    parameter int unsigned DATA_W  = 12
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               load_i,
    input  logic [ANGLE_W-1:0] angle_i,
    input  logic               fault_i,
    output logic [DATA_W-1:0]  level_o,
    output logic               fault_o
);

    typedef struct packed {
        logic [DATA_W-1:0] level;
        logic              fault;
    } sample_state_t;

    sample_state_t      st_d, st_q;
    logic [DATA_W-1:0]  coarse;

    generate
        if (ANGLE_W >= DATA_W) begin : g_truncate
            assign coarse = angle_i[ANGLE_W-1 -: DATA_W];
        end else begin : g_extend
            assign coarse = {angle_i, {(DATA_W-ANGLE_W){1'b0}}};
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.level = coarse;
            st_d.fault = fault_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level_o = st_q.level;
    assign fault_o = st_q.fault;

    // R8: captured values are held between frame starts
    assert_frame_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> ($stable(level_o) && $stable(fault_o)));

endmodule

// File: rtl/pwm_frame_shaper.sv
module pwm_frame_shaper
    import pwm_frame_pkg::*;
#(
    parameter int unsigned DATA_W = 12
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              tick_i,
    input  frame_seg_e        seg_i,
    input  logic [DATA_W-1:0] data_idx_i,
    input  logic [DATA_W-1:0] level_i,
    input  logic              fault_i,
    output logic              pwm_o
);

    typedef struct packed {
        logic pwm;
    } shaper_state_t;

    shaper_state_t st_d, st_q;
    logic          period_lvl;

    always_comb begin
        unique case (seg_i)
            SEG_INIT: period_lvl = 1'b1;
            SEG_FLAG: period_lvl = !fault_i;
            SEG_DATA: period_lvl = !fault_i && (data_idx_i < level_i);
            default:  period_lvl = 1'b0;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (!en_i) begin
            st_d.pwm = 1'b0;
        end else if (tick_i) begin
            st_d.pwm = period_lvl;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pwm_o = st_q.pwm;

    assert_preamble_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && tick_i && seg_i == SEG_INIT) |=> pwm_o);

    // R4 and R6: a captured fault darkens everything after the first 12 periods
    assert_fault_dark_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && tick_i && fault_i && seg_i != SEG_INIT) |=> !pwm_o);

    assert_tail_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && tick_i && seg_i == SEG_TAIL) |=> !pwm_o);

    assert_disable_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !pwm_o);

    assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !tick_i) |=> $stable(pwm_o));

endmodule

// File: rtl/pwm_angle_frame_enc.sv
module pwm_angle_frame_enc
    import pwm_frame_pkg::*;
#(
    parameter int unsigned ANGLE_W  = 14,
    parameter int unsigned DATA_W   = 12,
    parameter int unsigned INIT_LEN = 12,
    parameter int unsigned FLAG_LEN = 4,
    parameter int unsigned TAIL_LEN = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               enable_i,
    input  logic               pwm_tick_i,
    input  logic [ANGLE_W-1:0] angle_i,
    input  logic               fault_i,
    output logic               pwm_o
);

    frame_seg_e        seg;
    logic [DATA_W-1:0] data_idx;
    logic              frame_start;
    logic [DATA_W-1:0] level;
    logic              fault_cap;

    pwm_frame_timer #(
        .INIT_LEN (INIT_LEN),
        .FLAG_LEN (FLAG_LEN),
        .DATA_W   (DATA_W),
        .TAIL_LEN (TAIL_LEN)
    ) timer_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (enable_i),
        .tick_i     (pwm_tick_i),
        .seg_o      (seg),
        .data_idx_o (data_idx),
        .start_o    (frame_start)
    );

    pwm_frame_sampler #(
        .ANGLE_W (ANGLE_W),
        .DATA_W  (DATA_W)
    ) sampler_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (frame_start),
        .angle_i (angle_i),
        .fault_i (fault_i),
        .level_o (level),
        .fault_o (fault_cap)
    );

    pwm_frame_shaper #(
        .DATA_W (DATA_W)
    ) shaper_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (enable_i),
        .tick_i     (pwm_tick_i),
        .seg_i      (seg),
        .data_idx_i (data_idx),
        .level_i    (level),
        .fault_i    (fault_cap),
        .pwm_o      (pwm_o)
    );

endmodule

// File: tb/pwm_angle_frame_enc_tb_top.sv
module pwm_angle_frame_enc_tb_top;

    localparam int FRAME = 4119;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        enable_i = 1'b0;
    logic        pwm_tick_i = 1'b0;
    logic [13:0] angle_i = '0;
    logic        fault_i = 1'b0;
    logic        pwm_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk_i = ~clk_i;

    pwm_angle_frame_enc dut_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .enable_i   (enable_i),
        .pwm_tick_i (pwm_tick_i),
        .angle_i    (angle_i),
        .fault_i    (fault_i),
        .pwm_o      (pwm_o)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
    endtask

    // Expected level of period p from the requirements
    function automatic bit exp_lvl(input int p, input int n, input bit flt);
        if (p < 12)        return 1'b1;
        else if (p < 16)   return !flt;
        else if (p < 4111) return !flt && ((p - 16) < n);
        else               return 1'b0;
    endfunction

    // Runs one full frame; called and returns at a falling edge with the strobe low
    task automatic run_frame(input logic [13:0] ang, input bit flt, input int gap);
        int n = int'(ang >> 2);
        int m_init = 0, m_flag = 0, m_data = 0, m_tail = 0, m_hold = 0;
        int hi_data = 0, hi_total = 0;
        string dreq;
        angle_i = ang;
        fault_i = flt;
        for (int p = 0; p < FRAME; p++) begin
            logic s;
            pwm_tick_i = 1'b1;
            @(negedge clk_i);
            pwm_tick_i = 1'b0;
            s = pwm_o;
            if (s) hi_total++;
            if (s != exp_lvl(p, n, flt)) begin
                if (p < 12) m_init++;
                else if (p < 16) m_flag++;
                else if (p < 4111) m_data++;
                else m_tail++;
            end
            if (p >= 16 && p < 4111 && s) hi_data++;
            if (p == 40) begin
                angle_i = 14'($urandom);
                fault_i = !flt;
            end
            for (int g = 0; g < gap; g++) begin
                @(negedge clk_i);
                if (pwm_o != s) m_hold++;
            end
        end
        dreq = flt ? "R6" : (((ang & 14'd3) != 0) ? "R10" : "R5");
        chk(m_init == 0, "R3", "preamble mismatches", m_init, 0);
        chk(m_flag == 0, "R4", "fault window mismatches", m_flag, 0);
        chk(m_data == 0, dreq, "data period mismatches", m_data, 0);
        chk(hi_data == (flt ? 0 : n), dreq, "data high count", hi_data, flt ? 0 : n);
        chk(m_tail == 0, "R7", "tail mismatches", m_tail, 0);
        chk(hi_total == (flt ? 12 : 16 + n), "R8", "frame high total after mid-frame change",
            hi_total, flt ? 12 : 16 + n);
        if (gap > 0)
            chk(m_hold == 0, "R2", "changes between strobes", m_hold, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk_i);
        failures++;
        checks++;
        $display("FAIL R2 watchdog expired actual=%0d expected=%0d", 0, 1);
        report();
        $finish;
    end

    initial begin
        int lowcnt;
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk_i);
        chk(pwm_o == 1'b0, "R1", "output during reset", int'(pwm_o), 0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        enable_i = 1'b1;
        repeat (3) @(negedge clk_i);
        chk(pwm_o == 1'b0, "R1", "output enabled without strobe", int'(pwm_o), 0);

        // Directed corners, frames back to back (R2 alignment)
        run_frame(14'h0000, 1'b0, 0);
        run_frame(14'h3FFF, 1'b0, 0);
        run_frame(14'h0003, 1'b0, 0);   // R10: low bits alone give N = 0
        run_frame(14'h0007, 1'b0, 0);   // R10: N = 1
        run_frame(14'h3FFF, 1'b1, 0);   // R4 R6
        run_frame(14'h2000, 1'b0, 2);   // R2: idle cycles between strobes

        // Random frames
        for (int i = 0; i < 8; i++) begin
            logic [13:0] a = 14'($urandom);
            bit f = (($urandom % 4) == 0);
            run_frame(a, f, 0);
        end

        // R9: disable in the middle of a frame, together with a strobe
        angle_i = 14'h3FFF;
        fault_i = 1'b0;
        lowcnt = 0;
        for (int p = 0; p < 30; p++) begin
            pwm_tick_i = 1'b1;
            @(negedge clk_i);
            pwm_tick_i = 1'b0;
            if (!pwm_o) lowcnt++;
        end
        chk(lowcnt == 0, "R3", "partial frame preamble low periods", lowcnt, 0);
        enable_i = 1'b0;
        pwm_tick_i = 1'b1;
        @(negedge clk_i);
        chk(pwm_o == 1'b0, "R9", "output after disable", int'(pwm_o), 0);
        lowcnt = 0;
        for (int c = 0; c < 20; c++) begin
            pwm_tick_i = c[0];
            @(negedge clk_i);
            if (pwm_o) lowcnt++;
        end
        chk(lowcnt == 0, "R9", "high samples while disabled", lowcnt, 0);
        pwm_tick_i = 1'b0;
        enable_i = 1'b1;
        repeat (2) @(negedge clk_i);
        chk(pwm_o == 1'b0, "R9", "output re-enabled before strobe", int'(pwm_o), 0);
        run_frame(14'h1234, 1'b0, 0);   // R9: fresh frame from period 0

        report();
        $finish;
    end

endmodule